// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Pulse Generator

This block is a clocked monostable. It raises a pulse output for a programmed number of clock cycles when a qualified trigger arrives. Two gated trigger inputs set the condition. One is active low (`arm_n_i`) and one is active high (`arm_p_i`). An active-low clear (`clear_n_i`) both cuts a pulse short and, when it is released, can start one. The pulse length comes from `dur_i`, which is captured at the moment of each trigger, so no external timing parts are needed. The outputs are a registered pulse and its registered complement.

All three control inputs may change at any time relative to the clock. Each passes through its own synchronizer chain. Edges are found by comparing the newest synchronized sample with the previous one, so triggering depends only on levels and edges and never on how slowly an input moves. A trigger that arrives during a pulse restarts the count, so a steady stream of triggers holds the output high without a break. A synchronous reset models power-up. After reset a short settling window lets the synchronizers fill before any edge is believed, so no spurious pulse appears even if the inputs already sit at triggering levels.

Top module: `oneshot_gen`

## Requirements
- R1: While `rst_i` is high, and after it is released, `pulse_o` is 0 and `pulse_n_o` is 1. No pulse follows reset even when the inputs already hold `arm_n_i`=0, `arm_p_i`=1 and `clear_n_i`=1.
- R2: A rise of `arm_p_i` while `arm_n_i` is 0 and `clear_n_i` is 1 starts a pulse. `pulse_o` is first high after the third rising clock edge that samples the new input level.
- R3: A fall of `arm_n_i` while `arm_p_i` is 1 and `clear_n_i` is 1 starts a pulse, with the same latency as R2.
- R4: A rise of `clear_n_i` while `arm_n_i` is 0 and `arm_p_i` is 1 starts a pulse, with the same latency as R2.
- R5: None of the following starts a pulse: a rise of `arm_p_i` while `arm_n_i` is 1, a fall of `arm_n_i` while `arm_p_i` is 0, or a rise of `clear_n_i` while `arm_n_i` or `arm_p_i` is not at its active level.
- R6: `pulse_o` stays high for exactly `dur_i` clock cycles, using the value `dur_i` held when the trigger was detected. Later changes to `dur_i` do not alter a running pulse.
- R7: A trigger detected while `dur_i` is 0 produces no pulse.
- R8: A trigger during an active pulse reloads the count, and the pulse then ends `dur_i` cycles after that trigger's load.
- R9: A low level of `clear_n_i` forces `pulse_o` low with the same latency as R2. While `clear_n_i` stays low, edges on the trigger inputs have no effect.
- R10: `pulse_n_o` is always the complement of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset (power-up) |
| arm_n_i | input | 1 | Active-low gated trigger, asynchronous |
| arm_p_i | input | 1 | Active-high gated trigger, asynchronous |
| clear_n_i | input | 1 | Active-low clear, asynchronous; its release can trigger |
| dur_i | input | CNT_W | Pulse length in clock cycles, captured at each trigger |
| pulse_o | output | 1 | Registered pulse output |
| pulse_n_o | output | 1 | Registered complement of the pulse |

## Verification
An input change is taken in by the first rising edge after it. It passes two synchronizer flops and the edge history, and the load shows on `pulse_o` after the third such edge. A clear takes effect with the same latency. A pulse that is loaded at edge k is high for `dur_i` samples and is low again after edge k+`dur_i`. The bench drives inputs on falling edges and samples on falling edges. It numbers each sample from the stimulus and compares the index of the first high sample, the last high sample and the total number of high samples with values it computes from those offsets. This is done for every trigger path over a sweep of durations, for retrigger, for early clear and for reset.

// File: rtl/oneshot_gen.sv
`timescale 1ns/1ps
module oneshot_gen #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             arm_n_i,
  input  logic             arm_p_i,
  input  logic             clear_n_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  localparam int MSB    = SYNC_STAGES - 1;
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int SW     = $clog2(SETTLE + 1);

  logic [MSB:0]    sy_n, sy_p, sy_c;
  logic            hist_n, hist_p, hist_c;
  logic [SW-1:0]   settle_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic            ready, lvl_n, lvl_p, clr_lvl;
  logic            fall_n, rise_p, rise_c, fire;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          sy_n <= '0; sy_p <= '0; sy_c <= '0;
        end else begin
          sy_n <= arm_n_i; sy_p <= arm_p_i; sy_c <= clear_n_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          sy_n <= '0; sy_p <= '0; sy_c <= '0;
        end else begin
          sy_n <= {sy_n[MSB-1:0], arm_n_i};
          sy_p <= {sy_p[MSB-1:0], arm_p_i};
          sy_c <= {sy_c[MSB-1:0], clear_n_i};
        end
      end
    end
  endgenerate

  assign lvl_n   = sy_n[MSB];
  assign lvl_p   = sy_p[MSB];
  assign clr_lvl = sy_c[MSB];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_n   <= 1'b0;
      hist_p   <= 1'b0;
      hist_c   <= 1'b0;
      settle_q <= '0;
    end else begin
      hist_n <= lvl_n;
      hist_p <= lvl_p;
      hist_c <= clr_lvl;
      if (!ready) settle_q <= settle_q + 1'b1;
    end
  end

  assign ready  = (settle_q == SW'(SETTLE));
  assign fall_n = hist_n & ~lvl_n;
  assign rise_p = lvl_p & ~hist_p;
  assign rise_c = clr_lvl & ~hist_c;
  assign fire   = ready & clr_lvl &
                  ((rise_p & ~lvl_n) | (fall_n & lvl_p) | (rise_c & ~lvl_n & lvl_p));

  always_comb begin
    if (!clr_lvl)         cnt_nxt = '0;
    else if (fire)        cnt_nxt = dur_i;
    else if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
    else                  cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q     <= '0;
      pulse_o   <= 1'b0;
      pulse_n_o <= 1'b1;
    end else begin
      cnt_q     <= cnt_nxt;
      pulse_o   <= (cnt_nxt != '0);
      pulse_n_o <= (cnt_nxt == '0);
    end
  end

endmodule

// File: rtl/oneshot_gen_chk.sv
`timescale 1ns/1ps
module oneshot_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             clr_lvl,
  input logic             fire,
  input logic [CNT_W-1:0] dur_i,
  input logic             q,
  input logic             qn
);

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (!q && qn));

  a_r10_complement: assert property (@(posedge clk_i) disable iff (rst_i)
    qn == !q);

  a_r9_clear_ends: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_lvl |=> !q);

  a_r7_zero_len: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire && dur_i == '0) |=> !q);

  a_r6_load_high: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire && dur_i != '0) |=> q);

  a_r2_rise_cause: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(q) |-> $past(fire));

endmodule

bind oneshot_gen oneshot_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .clr_lvl (clr_lvl),
  .fire    (fire),
  .dur_i   (dur_i),
  .q       (pulse_o),
  .qn      (pulse_n_o)
);

// File: tb/test_oneshot_gen.sv
`timescale 1ns/1ps
module test_oneshot_gen;
  localparam int W = 8;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic an = 1'b1, ap = 1'b0, cn = 1'b1;
  logic [W-1:0] dur = '0;
  logic q, qn;
  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  oneshot_gen #(.CNT_W(W), .SYNC_STAGES(2)) i_oneshot_gen (
    .clk_i(clk), .rst_i(rst), .arm_n_i(an), .arm_p_i(ap), .clear_n_i(cn),
    .dur_i(dur), .pulse_o(q), .pulse_n_o(qn));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // samples numbered from 1 after a stimulus applied at a falling edge
  task automatic watch(input int win, input string req,
                       output int first, output int last, output int highs);
    first = 0; last = 0; highs = 0;
    for (int i = 1; i <= win; i++) begin
      tick();
      if (q) begin highs++; if (first == 0) first = i; last = i; end
      if (qn !== ~q) chk(0, "R10 complement", qn, ~q);
    end
    chk(1, req, 0, 0);
  endtask

  task automatic idle();
    an = 1'b1; ap = 1'b0; cn = 1'b1;
    for (int i = 0; i < 6; i++) tick();
  endtask

  task automatic expect_pulse(input string req, input int d, input int f, input int l, input int h);
    if (d == 0) begin
      chk(h == 0, {req, " R7 zero length highs"}, h, 0);
    end else begin
      chk(f == 3, {req, " first high"}, f, 3);
      chk(h == d, {req, " R6 high count"}, h, d);
      chk(l == d + 2, {req, " last high"}, l, d + 2);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int f, l, h;
    // R1: reset with triggering levels already present
    an = 1'b0; ap = 1'b1; cn = 1'b1; dur = 8'd5;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(q == 0 && qn == 1, "R1 outputs during reset", q, 0);
    end
    rst = 1'b0;
    watch(12, "R1 window", f, l, h);
    chk(h == 0, "R1 no pulse after reset", h, 0);
    idle();

    for (int d = 0; d <= 7; d++) begin
      dur = W'(d);
      // R2 path; arm_n fall with arm_p low must not trigger (R5)
      an = 1'b0;
      watch(6, "R5 arm_n fall with arm_p low", f, l, h);
      chk(h == 0, "R5 arm_n fall, arm_p low", h, 0);
      ap = 1'b1;
      watch(d + 6, "R2 window", f, l, h);
      expect_pulse("R2", d, f, l, h);
      idle();
      // R3 path; arm_p rise with arm_n high must not trigger (R5)
      ap = 1'b1;
      watch(6, "R5 arm_p rise with arm_n high", f, l, h);
      chk(h == 0, "R5 arm_p rise, arm_n high", h, 0);
      an = 1'b0;
      watch(d + 6, "R3 window", f, l, h);
      expect_pulse("R3", d, f, l, h);
      idle();
      // R4 path; levels applied while clear is low are ignored (R9)
      cn = 1'b0; tick(); an = 1'b0; tick(); ap = 1'b1;
      watch(6, "R9 clear held low", f, l, h);
      chk(h == 0, "R9 triggers ignored while clear low", h, 0);
      cn = 1'b1;
      watch(d + 6, "R4 window", f, l, h);
      expect_pulse("R4", d, f, l, h);
      idle();
    end

    // R5: clear release with arm_p low, and with arm_n high
    cn = 1'b0; an = 1'b0; ap = 1'b0; tick(); tick(); tick(); dur = 8'd4;
    cn = 1'b1;
    watch(8, "R5 clear rise, arm_p low", f, l, h);
    chk(h == 0, "R5 clear rise with arm_p low", h, 0);
    cn = 1'b0; an = 1'b1; ap = 1'b1; tick(); tick(); tick();
    cn = 1'b1;
    watch(8, "R5 clear rise, arm_n high", f, l, h);
    chk(h == 0, "R5 clear rise with arm_n high", h, 0);
    idle();

    // R6: duration captured at trigger, later change ignored
    dur = 8'd5; an = 1'b0; tick(); tick(); tick();
    ap = 1'b1; f = 0; l = 0; h = 0;
    for (int i = 1; i <= 14; i++) begin
      tick();
      if (q) begin h++; if (f == 0) f = i; l = i; end
      if (i == 3) dur = 8'd1;
    end
    chk(h == 5, "R6 dur change mid-pulse ignored", h, 5);
    chk(l == 7, "R6 end of pulse", l, 7);
    idle();

    // R8: retrigger via arm_p after 6 samples, dur 6 -> high 3..14
    dur = 8'd6; an = 1'b0; tick(); tick(); tick();
    ap = 1'b1; f = 0; l = 0; h = 0;
    for (int i = 1; i <= 22; i++) begin
      tick();
      if (q) begin h++; if (f == 0) f = i; l = i; end
      if (i == 4) ap = 1'b0;
      if (i == 6) ap = 1'b1;
    end
    chk(f == 3, "R8 first high", f, 3);
    chk(l == 14, "R8 extended end", l, 14);
    chk(h == 12, "R8 continuous high", h, 12);
    idle();

    // R8: sustained retriggers keep the output high throughout
    dur = 8'd4; an = 1'b0; tick(); tick(); tick();
    h = 0;
    for (int i = 1; i <= 40; i++) begin
      ap = ~ap;
      tick();
      if (i >= 3 && q) h++;
    end
    chk(h == 38, "R8 full duty under retrigger", h, 38);
    idle();

    // R9: early clear, dur 20, clear after sample 5 -> high 3..7
    dur = 8'd20; an = 1'b0; tick(); tick(); tick();
    ap = 1'b1; f = 0; l = 0; h = 0;
    for (int i = 1; i <= 30; i++) begin
      tick();
      if (q) begin h++; if (f == 0) f = i; l = i; end
      if (i == 5) cn = 1'b0;
      if (i == 12) ap = 1'b0;
      if (i == 15) ap = 1'b1;
    end
    chk(l == 7, "R9 clear cuts pulse", l, 7);
    chk(h == 5, "R9 high count before clear", h, 5);
    chk(q == 0 && qn == 1, "R10 state after clear", qn, 1);
    idle();

    // R1: reset during a pulse
    dur = 8'd30; an = 1'b0; tick(); tick(); tick();
    ap = 1'b1; for (int i = 0; i < 5; i++) tick();
    chk(q == 1, "R2 pulse running before reset", q, 1);
    rst = 1'b1; tick();
    chk(q == 0 && qn == 1, "R1 reset ends pulse", q, 0);
    rst = 1'b0;
    watch(40, "R1 after mid reset", f, l, h);
    chk(h == 0, "R1 no pulse after mid reset", h, 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule